// File: doc/BRIEF.md
# HDB3 Line Code Decoder

This block turns a dual-rail pseudo-ternary line signal into a plain NRZ bit stream. One rail carries the positive marks of the line, the other the negative marks. Both rails are asynchronous to the system clock. Each rail is caught by its own set-reset style capture flop, which is cleared once the clock domain has taken its sample. This lets a line pulse land anywhere in the low phase of the clock without being lost or counted twice.

In the clock domain, each sampled slot is classed as a space, a positive mark or a negative mark. A mark whose polarity repeats the previous mark is a bipolar violation, which is how the line code signals a substituted run of four zeros. A four-stage delay line holds the decoded bits. A violation therefore zeroes both its own slot and the slot three positions earlier, which holds the balancing pulse of the B00V form. The NRZ bit leaves the end of the delay line.

Two alarms watch the line. One pulses when a violation repeats the polarity of the previous violation. The other goes high after a run of eleven empty slots. A purely combinational OR of the two rails is provided to help an external circuit recover the clock.

Top module: `hdb3_line_decoder`

## Requirements
- R1: A valid line-coded stream decodes to its original data on `nrz_out`. A slot sampled at clock edge k appears on `nrz_out` right after edge k+4 and holds for one cycle.
- R2: A mark with the same polarity as the previous mark is a violation, and its slot is output as 0.
- R3: When a violation is sampled, the slot sampled three edges earlier is also output as 0. This removes the balancing pulse of a B00V substitution.
- R4: `dpv_alarm` is high for exactly the one cycle after a violation is sampled whose polarity equals that of the previous violation. It stays low on the first violation after reset.
- R5: `loi_alarm` goes high after the edge that samples the eleventh consecutive empty slot. It stays high through further empty slots and drops after the edge that samples any mark. Ten empty slots do not raise it.
- R6: `clk_rec` equals `rail_pos | rail_neg` at all times, with no register in the path.
- R7: Every rail pulse is counted exactly once, including marks in back-to-back slots, when each pulse rises during the low phase of the clock.
- R8: While `rst_n` is low at a clock edge, `nrz_out`, `dpv_alarm` and `loi_alarm` read 0 after that edge. The last-mark polarity resets to negative, so a first positive mark after reset decodes as 1.
- R9: A slot where both rails pulse is taken as a positive mark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (nominally 2.048 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_pos | input | 1 | Positive-mark rail, asynchronous return-to-zero pulses |
| rail_neg | input | 1 | Negative-mark rail, asynchronous return-to-zero pulses |
| nrz_out | output | 1 | Decoded NRZ data, four edges after sampling |
| dpv_alarm | output | 1 | One-cycle pulse on a violation repeating the previous violation polarity |
| loi_alarm | output | 1 | High while eleven or more empty slots have been sampled in a row |
| clk_rec | output | 1 | Combinational OR of the two rails, for clock recovery |

## Verification
The bench drives B00V and 000V substitutions. A design that cleared the wrong delay stage would leak a 1 for the balancing pulse or wipe a genuine data bit. Back-to-back marks of alternating polarity expose a capture flop whose clear overlaps the next pulse, which would drop every other mark. Runs of exactly ten and eleven empty slots, and a violation that repeats or alternates the last violation polarity, show off-by-one counter limits and an alarm raised on the first violation after reset. Both-rails slots and the first mark after reset check the polarity priority and the reset value of the polarity register.

// File: rtl/hdb3_pkg.sv
`timescale 1ns/1ps
package hdb3_pkg;

    // Length of a zero substitution on the line; fixed by the code itself
    localparam int SUB_LEN = 4;

    typedef enum logic {
        POL_NEG = 1'b0,
        POL_POS = 1'b1
    } pol_e;

    // Registered state of the substitution stripper
    typedef struct packed {
        logic [SUB_LEN-1:0] line;      // decoded bits, [0] newest
        pol_e               last_mark; // polarity of the latest mark
        logic               v_seen;    // a violation was seen since reset
        pol_e               last_v;    // polarity of the latest violation
        logic               dpv;       // repeated-violation alarm
    } strip_st_t;

endpackage

// File: rtl/hdb3_rail_catch.sv
`timescale 1ns/1ps
module hdb3_rail_catch #(
    parameter int NRAIL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NRAIL-1:0] rail_i,
    output logic [NRAIL-1:0] smp_o
);

    logic [NRAIL-1:0] hold_w;
    logic [NRAIL-1:0] smp_d, smp_q;

    // Per-rail capture flop: set by the line pulse edge, cleared in the high
    // phase of the clock once the sample flop has taken a one (or in reset).
    for (genvar g = 0; g < NRAIL; g++) begin : g_rail
        logic hold_q;
        logic clr_w;

        assign clr_w = (smp_q[g] | ~rst_n) & clk;

        always_ff @(posedge rail_i[g] or posedge clr_w) begin
            if (clr_w) hold_q <= 1'b0;
            else       hold_q <= 1'b1;
        end

        assign hold_w[g] = hold_q;
    end

    always_comb begin
        smp_d = rst_n ? hold_w : '0;
    end

    always_ff @(posedge clk) begin
        smp_q <= smp_d;
    end

    assign smp_o = smp_q;

endmodule

// File: rtl/hdb3_sub_strip.sv
`timescale 1ns/1ps
module hdb3_sub_strip
    import hdb3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_pos,
    input  logic smp_neg,
    output logic nrz_o,
    output logic dpv_o
);

    localparam int BAL_IDX = SUB_LEN - 2; // stage holding the balancing pulse

    strip_st_t st_d, st_q;
    logic      mark;
    logic      viol;
    pol_e      pol;

    always_comb begin
        mark = smp_pos | smp_neg;
        pol  = smp_pos ? POL_POS : POL_NEG;      // positive rail wins a tie
        viol = mark && (pol == st_q.last_mark);

        st_d      = st_q;
        st_d.line = {st_q.line[BAL_IDX:0], mark & ~viol};
        if (viol) begin
            st_d.line[SUB_LEN-1] = 1'b0;         // balancing pulse of B00V
        end
        if (mark) begin
            st_d.last_mark = pol;
        end
        st_d.dpv = viol && st_q.v_seen && (pol == st_q.last_v);
        if (viol) begin
            st_d.v_seen = 1'b1;
            st_d.last_v = pol;
        end

        if (!rst_n) begin
            st_d = '{line: '0, last_mark: POL_NEG, v_seen: 1'b0,
                     last_v: POL_NEG, dpv: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign nrz_o = st_q.line[SUB_LEN-1];
    assign dpv_o = st_q.dpv;

    // R1
    nrz_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nrz_o |-> $past(mark, 4));

    // R2
    nrz_not_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nrz_o |-> !$past(viol, 4));

    // R4
    dpv_needs_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dpv_o |-> $past(smp_pos | smp_neg));

endmodule

// File: rtl/hdb3_loss_mon.sv
`timescale 1ns/1ps
module hdb3_loss_mon #(
    parameter int LOS_ZEROS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_pos,
    input  logic smp_neg,
    output logic loi_o
);

    localparam int CW = $clog2(LOS_ZEROS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOS_ZEROS);

    typedef struct packed {
        logic [CW-1:0] run;
    } loss_st_t;

    loss_st_t st_d, st_q;
    logic     mark;

    always_comb begin
        mark = smp_pos | smp_neg;
        st_d = st_q;
        if (mark) begin
            st_d.run = '0;
        end else if (st_q.run != LIMIT) begin
            st_d.run = st_q.run + 1'b1;
        end
        if (!rst_n) begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign loi_o = (st_q.run == LIMIT);

    // R5
    loi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loi_o && (smp_pos || smp_neg)) |=> !loi_o);

    // R5
    loi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loi_o) |-> $past(!(smp_pos || smp_neg)));

endmodule

// File: rtl/hdb3_line_decoder.sv
`timescale 1ns/1ps
module hdb3_line_decoder #(
    parameter int LOS_ZEROS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_pos,
    input  logic rail_neg,
    output logic nrz_out,
    output logic dpv_alarm,
    output logic loi_alarm,
    output logic clk_rec
);

    logic [1:0] smp;

    hdb3_rail_catch #(.NRAIL(2)) u_catch (
        .clk    (clk),
        .rst_n  (rst_n),
        .rail_i ({rail_neg, rail_pos}),
        .smp_o  (smp)
    );

    hdb3_sub_strip u_strip (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_pos (smp[0]),
        .smp_neg (smp[1]),
        .nrz_o   (nrz_out),
        .dpv_o   (dpv_alarm)
    );

    hdb3_loss_mon #(.LOS_ZEROS(LOS_ZEROS)) u_loss (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_pos (smp[0]),
        .smp_neg (smp[1]),
        .loi_o   (loi_alarm)
    );

    assign clk_rec = rail_pos | rail_neg;

endmodule

// File: tb/hdb3_line_decoder_test.sv
`timescale 1ns/1ps
module hdb3_line_decoder_test;

    localparam int MAXS = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rail_pos = 1'b0;
    logic rail_neg = 1'b0;
    logic nrz_out, dpv_alarm, loi_alarm, clk_rec;

    always #2.5 clk = ~clk;

    hdb3_line_decoder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rail_pos  (rail_pos),
        .rail_neg  (rail_neg),
        .nrz_out   (nrz_out),
        .dpv_alarm (dpv_alarm),
        .loi_alarm (loi_alarm),
        .clk_rec   (clk_rec)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    int    sym_a   [MAXS];
    bit    exp_nrz [MAXS];
    bit    exp_dpv [MAXS];
    bit    exp_loi [MAXS];
    string tag_a   [MAXS];
    int    nsym = 0;

    // reference state; one empty slot leaves the sample register at release
    bit m_last_pos = 1'b0;
    bit m_vseen = 1'b0;
    bit m_last_vpos = 1'b0;
    int m_run = 1;

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // s: 0 space, 1 positive, -1 negative, 2 both rails
    function automatic void model_push(int s);
        bit mark, pos, viol;
        mark = (s != 0);
        pos  = (s == 1) || (s == 2);
        viol = mark && (pos == m_last_pos);
        sym_a[nsym]   = s;
        exp_nrz[nsym] = mark && !viol;
        tag_a[nsym]   = "R1";
        if (mark && nsym > 0 && sym_a[nsym-1] != 0 && !viol) tag_a[nsym] = "R7";
        if (viol) tag_a[nsym] = "R2";
        if (s == 2) tag_a[nsym] = "R9";
        if (nsym == 0 && mark) tag_a[nsym] = "R8";
        if (viol && nsym >= 3 && exp_nrz[nsym-3]) begin
            exp_nrz[nsym-3] = 1'b0;
            tag_a[nsym-3]   = "R3";
        end
        exp_dpv[nsym] = viol && m_vseen && (pos == m_last_vpos);
        if (viol) begin
            m_vseen     = 1'b1;
            m_last_vpos = pos;
        end
        if (mark) m_last_pos = pos;
        if (mark) m_run = 0;
        else if (m_run < 11) m_run++;
        exp_loi[nsym] = (m_run >= 11);
        nsym++;
    endfunction

    // Called at a falling edge; leaves at the next falling edge.
    task automatic step(int s);
        int k;
        k = nsym;
        model_push(s);
        if (k >= 5) chk(tag_a[k-5], "nrz_out", int'(nrz_out), int'(exp_nrz[k-5]));
        else        chk("R8", "nrz_out after reset", int'(nrz_out), 0);
        if (k >= 2) begin
            chk("R4", "dpv_alarm", int'(dpv_alarm), int'(exp_dpv[k-2]));
            chk("R5", "loi_alarm", int'(loi_alarm), int'(exp_loi[k-2]));
        end else begin
            chk("R8", "dpv_alarm after reset", int'(dpv_alarm), 0);
        end
        rail_pos = 1'b0;
        rail_neg = 1'b0;
        #0.5;
        chk("R6", "clk_rec idle", int'(clk_rec), 0);
        #0.5;
        rail_pos = (s == 1) || (s == 2);
        rail_neg = (s == -1) || (s == 2);
        #0.5;
        chk("R6", "clk_rec", int'(clk_rec), int'(s != 0));
        @(negedge clk);
    endtask

    // Line-code a data run and send it; dens_pct is the chance of a one.
    task automatic encode_run(int n, int dens_pct);
        bit d [2048];
        bit e_last;
        int e_marks;
        int i;
        for (int j = 0; j < n; j++) d[j] = (($urandom % 100) < dens_pct);
        e_last  = m_last_pos;
        e_marks = 0;
        i = 0;
        while (i < n) begin
            if (i + 3 < n && !d[i] && !d[i+1] && !d[i+2] && !d[i+3]) begin
                if (e_marks % 2 == 1) begin
                    step(0); step(0); step(0);
                    step(e_last ? 1 : -1);
                end else begin
                    e_last = !e_last;
                    step(e_last ? 1 : -1);
                    step(0); step(0);
                    step(e_last ? 1 : -1);
                end
                e_marks = 0;
                i += 4;
            end else if (d[i]) begin
                e_last = !e_last;
                step(e_last ? 1 : -1);
                e_marks++;
                i++;
            end else begin
                step(0);
                i++;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R8", "nrz_out in reset", int'(nrz_out), 0);
        chk("R8", "dpv_alarm in reset", int'(dpv_alarm), 0);
        chk("R8", "loi_alarm in reset", int'(loi_alarm), 0);
        rst_n = 1'b1;

        // R8: first positive mark after reset is data; R7 back-to-back marks
        step(1); step(-1);
        // R3: B00V (B positive, V positive)
        step(1); step(0); step(0); step(1);
        step(-1);
        // 000V after an odd mark count, V negative
        step(0); step(0); step(0); step(-1);
        // R4: alternating violation, then a repeated one
        step(1); step(1); step(1);
        // R5: long empty run
        for (int j = 0; j < 14; j++) step(0);
        // R9: both rails after a positive mark (violation), then a fresh one
        step(2); step(-1); step(2);
        // random coded traffic, dense and sparse
        encode_run(1500, 50);
        encode_run(1500, 20);
        // R5 boundary: ten empty slots then eleven
        step(-1);
        for (int j = 0; j < 10; j++) step(0);
        step(1);
        for (int j = 0; j < 11; j++) step(0);
        step(0);
        step(-1);
        for (int j = 0; j < 6; j++) step(0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule